// File: doc/BRIEF.md
# Two-Channel Burst PWM Generator

This block drives two independent pulse-width-modulated outputs. Each channel holds a high duration, a low duration and a burst length. The durations count in timebase ticks, and one tick is 100 microseconds. A shared divider derives the tick from the core clock. Each period begins with the high phase and is followed by the low phase. A burst length of zero lets the channel run without end. A nonzero burst length stops the channel after that many complete periods and clears its enable bit.

Configuration arrives from a mailbox decoder as a one-cycle write strobe that carries an 8-bit command code and a 16-bit value. An enable mask starts and stops the channels. The usual arming sequence has three steps: disable the channel, load its burst length, then enable it again. A combinational query port returns any stored setting when given the command code that writes it.

Top module: `twin_burst_pwm`

## Requirements
- R1: After reset both outputs are low, the enable mask reads 0, every duration reads 1 and every burst length reads 0.
- R2: Writing code 0x10+2n stores the high duration of channel n, and writing code 0x11+2n stores its low duration. A query with the same code returns the stored value unchanged.
- R3: A written duration of 0 is stored as 1, so a duration is never zero.
- R4: Writes to the duration codes or to a burst code (0x14+n) of a channel whose enable bit is set are ignored.
- R5: Code 0x1F writes the enable mask. Bit n of the value enables channel n, value bits above the channel count are dropped, and query 0x1F returns the mask in the low bits.
- R6: In the cycle after a channel's enable bit goes from 0 to 1, its output is high. The high phase then lasts the high duration in ticks and the low phase the low duration in ticks. One tick is a single-cycle pulse every CLK_DIV clocks, free-running from reset.
- R7: A channel whose burst length is 0 repeats its period for as long as it stays enabled.
- R8: A channel whose burst length is N stops after the N-th complete period. In the next cycle its output is low and its enable bit is clear.
- R9: Clearing a channel's enable bit forces its output low in the next cycle. A later re-enable restarts the channel with a full high phase.
- R10: If a write to 0x1F falls in the same cycle as a burst completion, the written mask wins. A channel kept enabled in this way starts a new period in its high phase.
- R11: Commands with codes outside the defined set change nothing, and querying such a code returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | One-cycle configuration write strobe |
| cfg_cmd | input | 8 | Command code of the write |
| cfg_val | input | 16 | Parameter value of the write |
| qry_sel | input | 8 | Command code whose stored value is returned |
| qry_data | output | 16 | Stored value selected by qry_sel |
| pwm_out | output | 2 | PWM outputs, bit n for channel n |

## Verification
Two events can land on the same clock edge: a channel's own burst completion, which clears its enable bit, and a write of the enable mask from the command side. The bench forces this collision by watching its reference model. When the model predicts that the next edge ends the burst, the bench drives the mask write in that same cycle. The result is judged through the query port and the output, which must show the written mask and a fresh high phase.

// File: rtl/bpwm_pkg.sv
package bpwm_pkg;
  localparam int CMD_W = 8;
  typedef logic [CMD_W-1:0] cmd_t;

  localparam cmd_t CMD_EN_MASK = 8'h1F;

  function automatic cmd_t cmd_high(input int ch);
    return cmd_t'(16 + 2 * ch);
  endfunction

  function automatic cmd_t cmd_low(input int ch);
    return cmd_t'(17 + 2 * ch);
  endfunction

  function automatic cmd_t cmd_burst(input int ch);
    return cmd_t'(20 + ch);
  endfunction

  typedef enum logic {
    PH_HIGH = 1'b0,
    PH_LOW  = 1'b1
  } phase_e;
endpackage

// File: rtl/bpwm_tick_gen.sv
module bpwm_tick_gen #(
  parameter int CLK_DIV = 10000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [W-1:0] LAST = W'(CLK_DIV - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bpwm_cfg_regs.sv
module bpwm_cfg_regs
  import bpwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DUR_W  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_wr,
  input  cmd_t                         cfg_cmd,
  input  logic [DUR_W-1:0]             cfg_val,
  input  logic [NUM_CH-1:0]            chan_done,
  input  cmd_t                         qry_sel,
  output logic [NUM_CH-1:0]            en_mask,
  output logic [NUM_CH-1:0][DUR_W-1:0] hi_dur,
  output logic [NUM_CH-1:0][DUR_W-1:0] lo_dur,
  output logic [NUM_CH-1:0][DUR_W-1:0] burst_len,
  output logic [DUR_W-1:0]             qry_data
);
  localparam logic [DUR_W-1:0] DUR_MIN = DUR_W'(1);

  logic [NUM_CH-1:0] mask_d;
  logic [DUR_W-1:0]  dur_val;
  logic              mask_wr;

  assign dur_val = (cfg_val == '0) ? DUR_MIN : cfg_val;
  assign mask_wr = cfg_wr && (cfg_cmd == CMD_EN_MASK);

  // Enable mask: completion clears a bit, a mask write overrides both
  always_comb begin
    mask_d = en_mask & ~chan_done;
    if (mask_wr) mask_d = cfg_val[NUM_CH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_mask <= '0;
    else        en_mask <= mask_d;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic             wr_hi, wr_lo, wr_bu;
    logic [DUR_W-1:0] hi_d, lo_d, bu_d;

    always_comb begin
      wr_hi = cfg_wr && !en_mask[g] && (cfg_cmd == cmd_high(g));
      wr_lo = cfg_wr && !en_mask[g] && (cfg_cmd == cmd_low(g));
      wr_bu = cfg_wr && !en_mask[g] && (cfg_cmd == cmd_burst(g));
      hi_d  = wr_hi ? dur_val : hi_dur[g];
      lo_d  = wr_lo ? dur_val : lo_dur[g];
      bu_d  = wr_bu ? cfg_val : burst_len[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_dur[g]    <= DUR_MIN;
        lo_dur[g]    <= DUR_MIN;
        burst_len[g] <= '0;
      end else begin
        hi_dur[g]    <= hi_d;
        lo_dur[g]    <= lo_d;
        burst_len[g] <= bu_d;
      end
    end
  end

  // Readback: the code that writes a setting also selects it
  always_comb begin
    qry_data = '0;
    if (qry_sel == CMD_EN_MASK) qry_data = DUR_W'(en_mask);
    for (int i = 0; i < NUM_CH; i++) begin
      if (qry_sel == cmd_high(i))  qry_data = hi_dur[i];
      if (qry_sel == cmd_low(i))   qry_data = lo_dur[i];
      if (qry_sel == cmd_burst(i)) qry_data = burst_len[i];
    end
  end
endmodule

// File: rtl/bpwm_chan.sv
module bpwm_chan
  import bpwm_pkg::*;
#(
  parameter int DUR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic [DUR_W-1:0] hi_len,
  input  logic [DUR_W-1:0] lo_len,
  input  logic [DUR_W-1:0] burst_len,
  output logic             pwm,
  output logic             done
);
  phase_e           phase_q, phase_d;
  logic [DUR_W-1:0] cnt_q, cnt_d;
  logic [DUR_W-1:0] per_q, per_d;
  logic [DUR_W-1:0] limit;
  logic             phase_end;
  logic             burst_end;
  logic             bursting;

  always_comb begin
    limit     = (phase_q == PH_HIGH) ? hi_len : lo_len;
    bursting  = (burst_len != '0);
    phase_end = tick && (cnt_q == limit - 1'b1);
    burst_end = phase_end && (phase_q == PH_LOW) && bursting &&
                (per_q == burst_len - 1'b1);
    done      = en && burst_end;
    pwm       = en && (phase_q == PH_HIGH);
  end

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    per_d   = per_q;
    if (!en) begin
      phase_d = PH_HIGH;
      cnt_d   = '0;
      per_d   = '0;
    end else if (tick) begin
      if (phase_end) begin
        cnt_d = '0;
        if (phase_q == PH_HIGH) begin
          phase_d = PH_LOW;
        end else begin
          phase_d = PH_HIGH;
          if (burst_end)     per_d = '0;
          else if (bursting) per_d = per_q + 1'b1;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_HIGH;
      cnt_q   <= '0;
      per_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      per_q   <= per_d;
    end
  end
endmodule

// File: rtl/twin_burst_pwm.sv
module twin_burst_pwm
  import bpwm_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int DUR_W   = 16,
  parameter int CLK_DIV = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_cmd,
  input  logic [15:0]       cfg_val,
  input  logic [7:0]        qry_sel,
  output logic [15:0]       qry_data,
  output logic [NUM_CH-1:0] pwm_out
);
  logic                         rst_meta_q;
  logic                         rst_sync_n;
  logic                         tick;
  logic [NUM_CH-1:0]            en_mask;
  logic [NUM_CH-1:0]            chan_done;
  logic [NUM_CH-1:0][DUR_W-1:0] hi_dur;
  logic [NUM_CH-1:0][DUR_W-1:0] lo_dur;
  logic [NUM_CH-1:0][DUR_W-1:0] burst_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  bpwm_tick_gen #(.CLK_DIV(CLK_DIV)) tick_i (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .tick (tick)
  );

  bpwm_cfg_regs #(.NUM_CH(NUM_CH), .DUR_W(DUR_W)) cfg_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cfg_wr   (cfg_wr),
    .cfg_cmd  (cfg_cmd),
    .cfg_val  (cfg_val),
    .chan_done(chan_done),
    .qry_sel  (qry_sel),
    .en_mask  (en_mask),
    .hi_dur   (hi_dur),
    .lo_dur   (lo_dur),
    .burst_len(burst_len),
    .qry_data (qry_data)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    bpwm_chan #(.DUR_W(DUR_W)) chan_i (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .tick     (tick),
      .en       (en_mask[g]),
      .hi_len   (hi_dur[g]),
      .lo_len   (lo_dur[g]),
      .burst_len(burst_len[g]),
      .pwm      (pwm_out[g]),
      .done     (chan_done[g])
    );
  end
endmodule

// File: rtl/twin_burst_pwm_chk.sv
module twin_burst_pwm_chk
  import bpwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DUR_W  = 16
) (
  input logic                         clk,
  input logic                         rst_sync_n,
  input logic                         cfg_wr,
  input logic [7:0]                   cfg_cmd,
  input logic [15:0]                  cfg_val,
  input logic [NUM_CH-1:0]            en_mask,
  input logic [NUM_CH-1:0]            chan_done,
  input logic [NUM_CH-1:0][DUR_W-1:0] hi_dur,
  input logic [NUM_CH-1:0][DUR_W-1:0] lo_dur,
  input logic [NUM_CH-1:0][DUR_W-1:0] burst_len,
  input logic [NUM_CH-1:0]            pwm_out
);
  logic mask_wr;
  assign mask_wr = cfg_wr && (cfg_cmd == CMD_EN_MASK);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    a_r3_dur_nonzero: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (hi_dur[g] != '0) && (lo_dur[g] != '0));

    a_r4_locked_while_on: assert property (@(posedge clk) disable iff (!rst_sync_n)
      en_mask[g] |=> ($stable(hi_dur[g]) && $stable(lo_dur[g]) && $stable(burst_len[g])));

    a_r6_start_high: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (mask_wr && cfg_val[g] && !en_mask[g]) |=> pwm_out[g]);

    a_r9_stop_low: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (mask_wr && !cfg_val[g]) |=> !pwm_out[g]);

    a_r8_done_clears: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (chan_done[g] && !mask_wr) |=> (!en_mask[g] && !pwm_out[g]));

    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (chan_done[g] && mask_wr && cfg_val[g]) |=> (en_mask[g] && pwm_out[g]));
  end
endmodule

bind twin_burst_pwm twin_burst_pwm_chk #(.NUM_CH(NUM_CH), .DUR_W(DUR_W)) chk_i (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .cfg_wr    (cfg_wr),
  .cfg_cmd   (cfg_cmd),
  .cfg_val   (cfg_val),
  .en_mask   (en_mask),
  .chan_done (chan_done),
  .hi_dur    (hi_dur),
  .lo_dur    (lo_dur),
  .burst_len (burst_len),
  .pwm_out   (pwm_out)
);

// File: tb/twin_burst_pwm_tb_top.sv
`timescale 1ns/1ps
module twin_burst_pwm_tb_top;
  localparam int DIV = 5;
  localparam int NCH = 2;

  logic        clk;
  logic        rst_n;
  logic        cfg_wr;
  logic [7:0]  cfg_cmd;
  logic [15:0] cfg_val;
  logic [7:0]  qry_sel;
  logic [15:0] qry_data;
  logic [1:0]  pwm_out;

  int  n_run;
  int  n_fail;
  bit  finished;

  // reference model state
  bit  m_s0, m_s1, m_live;
  int  m_div;
  bit  m_en    [NCH];
  bit  m_ph_hi [NCH];
  int  m_cnt   [NCH];
  int  m_pc    [NCH];
  int  m_hi    [NCH];
  int  m_lo    [NCH];
  int  m_bu    [NCH];
  bit  old_en  [NCH];
  bit  dn      [NCH];
  bit  tk;
  bit  old_live;
  int  lim;

  twin_burst_pwm #(.NUM_CH(NCH), .DUR_W(16), .CLK_DIV(DIV)) dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_wr  (cfg_wr),
    .cfg_cmd (cfg_cmd),
    .cfg_val (cfg_val),
    .qry_sel (qry_sel),
    .qry_data(qry_data),
    .pwm_out (pwm_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int model_qry(input int sel);
    int r;
    r = 0;
    if (sel == 'h1F) r = {30'd0, m_en[1], m_en[0]};
    for (int n = 0; n < NCH; n++) begin
      if (sel == 16 + 2 * n) r = m_hi[n];
      if (sel == 17 + 2 * n) r = m_lo[n];
      if (sel == 20 + n)     r = m_bu[n];
    end
    return r;
  endfunction

  function automatic bit done_next(input int n);
    return m_en[n] && (m_div == DIV - 1) && !m_ph_hi[n] &&
           (m_cnt[n] == m_lo[n] - 1) && (m_bu[n] != 0) && (m_pc[n] == m_bu[n] - 1);
  endfunction

  // cycle model, built from the requirements
  always @(posedge clk) begin
    old_live = m_s1;
    if (!rst_n) begin m_s1 = 0; m_s0 = 0; end
    else begin m_s1 = m_s0; m_s0 = 1; end
    if (!old_live) begin
      m_div = 0;
      for (int n = 0; n < NCH; n++) begin
        m_en[n] = 0; m_ph_hi[n] = 1; m_cnt[n] = 0; m_pc[n] = 0;
        m_hi[n] = 1; m_lo[n] = 1; m_bu[n] = 0;
      end
    end else begin
      tk = (m_div == DIV - 1);
      m_div = tk ? 0 : m_div + 1;
      for (int n = 0; n < NCH; n++) begin
        old_en[n] = m_en[n];
        dn[n] = 0;
        if (m_en[n]) begin
          if (tk) begin
            lim = m_ph_hi[n] ? m_hi[n] : m_lo[n];
            if (m_cnt[n] + 1 == lim) begin
              m_cnt[n] = 0;
              if (m_ph_hi[n]) m_ph_hi[n] = 0;
              else begin
                m_ph_hi[n] = 1;
                if (m_bu[n] != 0) begin
                  if (m_pc[n] + 1 == m_bu[n]) begin dn[n] = 1; m_pc[n] = 0; end
                  else m_pc[n]++;
                end
              end
            end else m_cnt[n]++;
          end
        end else begin
          m_ph_hi[n] = 1; m_cnt[n] = 0; m_pc[n] = 0;
        end
      end
      for (int n = 0; n < NCH; n++) begin
        if (cfg_wr && !old_en[n]) begin
          if (cfg_cmd == 8'(16 + 2 * n)) m_hi[n] = (cfg_val == 0) ? 1 : int'(cfg_val);
          if (cfg_cmd == 8'(17 + 2 * n)) m_lo[n] = (cfg_val == 0) ? 1 : int'(cfg_val);
          if (cfg_cmd == 8'(20 + n))     m_bu[n] = int'(cfg_val);
        end
        if (dn[n]) m_en[n] = 0;
        if (cfg_wr && cfg_cmd == 8'h1F) m_en[n] = cfg_val[n];
      end
    end
    m_live = m_s1;
  end

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // every-cycle comparison against the model (R6, R7)
  always @(negedge clk) begin
    if (rst_n && m_live && !finished) begin
      check("R6 pwm vs model", int'(pwm_out),
            {30'd0, m_en[1] && m_ph_hi[1], m_en[0] && m_ph_hi[0]});
      check("R2 query vs model", int'(qry_data), model_qry(int'(qry_sel)));
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic write(input logic [7:0] c, input logic [15:0] v);
    step();
    cfg_wr = 1'b1; cfg_cmd = c; cfg_val = v;
    step();
    cfg_wr = 1'b0;
  endtask

  function automatic int peek(input logic [7:0] s);
    qry_sel = s;
    return 0;
  endfunction

  task automatic qchk(input string req, input logic [7:0] s, input int exp);
    int unused;
    unused = peek(s);
    #1;
    check(req, int'(qry_data), exp);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    bit hit;
    n_run = 0; n_fail = 0; finished = 0;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_cmd = '0; cfg_val = '0; qry_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step();

    // R1 reset state
    check("R1 outputs low", int'(pwm_out), 0);
    qchk("R1 mask zero", 8'h1F, 0);
    qchk("R1 high duration one", 8'h10, 1);
    qchk("R1 low duration one", 8'h13, 1);
    qchk("R1 burst zero", 8'h15, 0);

    // R2 / R3 duration writes
    write(8'h10, 16'd3);
    write(8'h11, 16'd2);
    qchk("R2 ch0 high readback", 8'h10, 3);
    qchk("R2 ch0 low readback", 8'h11, 2);
    write(8'h12, 16'd0);
    qchk("R3 zero stored as one", 8'h12, 1);
    write(8'h13, 16'd4);
    write(8'h15, 16'd2);
    qchk("R2 ch1 burst readback", 8'h15, 2);

    // R11 undefined codes
    write(8'h16, 16'd5);
    write(8'h1E, 16'hFFFF);
    qchk("R11 undefined query zero", 8'h16, 0);
    qchk("R11 mask untouched", 8'h1F, 0);
    check("R11 outputs untouched", int'(pwm_out), 0);

    // R6 / R7 continuous ch0
    write(8'h1F, 16'h0001);
    check("R6 high after enable", int'(pwm_out[0]), 1);
    repeat (80) step();
    qchk("R7 still enabled", 8'h1F, 1);

    // R4 locked writes
    write(8'h10, 16'd9);
    write(8'h14, 16'd7);
    qchk("R4 high locked", 8'h10, 3);
    qchk("R4 burst locked", 8'h14, 0);

    // R5 / R8 burst on ch1 with upper value bits set
    write(8'h1F, 16'hFF03);
    qchk("R5 mask readback", 8'h1F, 3);
    check("R6 ch1 high after enable", int'(pwm_out[1]), 1);
    repeat (80) step();
    qchk("R8 enable cleared", 8'h1F, 1);
    check("R8 ch1 low after burst", int'(pwm_out[1]), 0);

    // R9 disable and restart
    write(8'h1F, 16'h0000);
    check("R9 low after disable", int'(pwm_out), 0);
    repeat (7) step();
    write(8'h1F, 16'h0001);
    check("R9 restart high", int'(pwm_out[0]), 1);
    repeat (20) step();

    // R10 collision of completion and mask write
    write(8'h1F, 16'h0000);
    write(8'h15, 16'd1);
    write(8'h1F, 16'h0002);
    hit = 0;
    for (int i = 0; i < 300 && !hit; i++) begin
      step();
      if (done_next(1)) begin
        hit = 1;
        cfg_wr = 1'b1; cfg_cmd = 8'h1F; cfg_val = 16'h0002;
        step();
        cfg_wr = 1'b0;
        qchk("R10 written mask wins", 8'h1F, 2);
        check("R10 new high phase", int'(pwm_out[1]), 1);
      end
    end
    check("R10 collision reached", int'(hit), 1);
    repeat (40) step();

    finished = 1;
    summary();
    $finish;
  end
endmodule